// File: doc/BRIEF.md
# Sliding-Window Rank-Order Selector

This block keeps the 32 most recent unsigned 16-bit samples of a stream in ascending order and reports the 24th smallest of them. It is meant to feed the threshold stage of an order-statistic detector. Each time the sample-valid strobe is high, the newest sample enters the window and the oldest one leaves it. The rank value for the updated window is registered at that same clock edge. A new statistic can therefore come out on every clock, with no gaps.

The window is a register array that is always sorted. Each stored slot compares itself with the incoming sample, and the comparison results across the array form a thermometer pattern. Each slot also carries a 5-bit arrival tag. The slot whose tag equals the write pointer holds the oldest sample. Removing that sample and inserting the new one both happen in the same cycle, and no stored element moves by more than one position.

After reset, every slot holds a placeholder. The placeholder ranks above every real sample, so placeholders are pushed off the top of the array as real samples arrive. They are never reported while the output is valid.

Top module: `rank_window_sel`

## Requirements
- R1: While rst_n is low, and at the first clock after it is released, out_valid is 0 and out_rank is 0. Every slot of the window holds the placeholder, which ranks above every 16-bit value.
- R2: out_valid is 0 until 32 samples have been accepted since reset. It goes to 1 at the clock edge that accepts the 32nd sample and stays at 1 until the next reset.
- R3: While out_valid is 1, out_rank equals the 24th smallest value, counting from 1 in ascending unsigned order, of the last 32 accepted samples. The value is updated at the edge that accepts the newest sample.
- R4: Samples are compared as unsigned numbers over the full range 0x0000 to 0xFFFF. A sample of 0xFFFF still sorts below the placeholder, and no placeholder is present in the window while out_valid is 1.
- R5: Equal samples each occupy their own slot and count separately toward the rank. A new sample is placed above stored entries of equal value.
- R6: While in_valid is 0, out_rank, out_valid and the whole window keep their values.
- R7: After every update the window is in non-decreasing order, with placeholders on top. Each slot's new content is either the new sample or the previous content of the same slot or of an adjacent slot.
- R8: In every cycle, exactly one slot's arrival tag matches the write pointer. The sample removed on each update is the one accepted 32 updates earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| in_valid | input | 1 | High when in_sample is to be accepted this clock |
| in_sample | input | 16 | Unsigned sample value |
| out_valid | output | 1 | High once the window holds 32 real samples |
| out_rank | output | 16 | 24th smallest value of the current window |

## Verification
The checker verifies several properties on every cycle: the window stays sorted, no element moves further than one slot, exactly one slot matches the age pointer, all state holds while the strobe is low, the valid flag is sticky and tracks the count of accepted samples, and no placeholder remains once the output is valid. Whether out_rank is the correct order statistic can only be shown by the bench. It compares out_rank against a window model that sorts independently. The stimulus includes ramps in both directions, constant runs, streams that alternate between the two extremes, small-alphabet streams dense with ties, and random streams with idle gaps and a reset in mid-run.

// File: rtl/rank_sel_pkg.sv
package rank_sel_pkg;
  // default geometry of the selector
  localparam int unsigned SEL_DATA_W = 16;
  localparam int unsigned SEL_DEPTH  = 32;
  localparam int unsigned SEL_RANK   = 24;  // 1-based, ascending

  // choice of per-slot comparison on a tie
  typedef enum logic {
    TIE_NEW_ABOVE = 1'b0,
    TIE_NEW_BELOW = 1'b1
  } tie_mode_e;
endpackage

// File: rtl/rank_slot_cmp.sv
module rank_slot_cmp
  import rank_sel_pkg::*;
#(
  parameter int unsigned DATA_W = SEL_DATA_W,
  parameter int unsigned DEPTH  = SEL_DEPTH,
  parameter tie_mode_e   TIE    = TIE_NEW_ABOVE,
  localparam int unsigned TAG_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][DATA_W-1:0] slot_val,
  input  logic [DEPTH-1:0]             slot_pad,
  input  logic [DEPTH-1:0][TAG_W-1:0]  slot_tag,
  input  logic [DATA_W-1:0]            in_sample,
  input  logic [TAG_W-1:0]             wr_ptr,
  output logic [DEPTH-1:0]             gt_vec,
  output logic [DEPTH-1:0]             del_vec
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    // a placeholder is larger than any real sample
    if (TIE == TIE_NEW_ABOVE) begin : g_strict
      assign gt_vec[i] = slot_pad[i] | (slot_val[i] > in_sample);
    end else begin : g_loose
      assign gt_vec[i] = slot_pad[i] | (slot_val[i] >= in_sample);
    end
    assign del_vec[i] = (slot_tag[i] == wr_ptr);
  end

endmodule

// File: rtl/rank_shift_net.sv
module rank_shift_net
  import rank_sel_pkg::*;
#(
  parameter int unsigned DATA_W = SEL_DATA_W,
  parameter int unsigned DEPTH  = SEL_DEPTH,
  localparam int unsigned TAG_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][DATA_W-1:0] slot_val,
  input  logic [DEPTH-1:0]             slot_pad,
  input  logic [DEPTH-1:0][TAG_W-1:0]  slot_tag,
  input  logic [DEPTH-1:0]             gt_vec,
  input  logic [DEPTH-1:0]             del_vec,
  input  logic [DATA_W-1:0]            in_sample,
  input  logic [TAG_W-1:0]             wr_ptr,
  output logic [DEPTH-1:0][DATA_W-1:0] nxt_val,
  output logic [DEPTH-1:0]             nxt_pad,
  output logic [DEPTH-1:0][TAG_W-1:0]  nxt_tag
);

  // compacted view: the array with the departing slot closed up
  logic [DEPTH-1:0]             at_or_above_del;
  logic [DEPTH-1:0][DATA_W-1:0] cmp_val;
  logic [DEPTH-1:0]             cmp_pad;
  logic [DEPTH-1:0][TAG_W-1:0]  cmp_tag;
  logic [DEPTH-1:0]             cmp_gt;
  // compacted view moved up by one slot (what slot i receives on a shift)
  logic [DEPTH-1:0][DATA_W-1:0] low_val;
  logic [DEPTH-1:0]             low_pad;
  logic [DEPTH-1:0][TAG_W-1:0]  low_tag;
  logic [DEPTH-1:0]             low_gt;
  logic                         seen_del;

  // prefix OR of the one-hot deletion vector
  always_comb begin
    seen_del = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      seen_del           = seen_del | del_vec[i];
      at_or_above_del[i] = seen_del;
    end
  end

  // close the gap left by the departing sample
  always_comb begin
    for (int i = 0; i < DEPTH - 1; i++) begin
      cmp_val[i] = at_or_above_del[i] ? slot_val[i+1] : slot_val[i];
      cmp_pad[i] = at_or_above_del[i] ? slot_pad[i+1] : slot_pad[i];
      cmp_tag[i] = at_or_above_del[i] ? slot_tag[i+1] : slot_tag[i];
      cmp_gt[i]  = at_or_above_del[i] ? gt_vec[i+1]   : gt_vec[i];
    end
    // the top slot is vacated by the compaction
    cmp_val[DEPTH-1] = slot_val[DEPTH-1];
    cmp_pad[DEPTH-1] = slot_pad[DEPTH-1];
    cmp_tag[DEPTH-1] = slot_tag[DEPTH-1];
    cmp_gt[DEPTH-1]  = 1'b1;
  end

  // one-position upward view of the compacted array
  always_comb begin
    low_val[0] = cmp_val[0];
    low_pad[0] = cmp_pad[0];
    low_tag[0] = cmp_tag[0];
    low_gt[0]  = 1'b0;
    for (int i = 1; i < DEPTH; i++) begin
      low_val[i] = cmp_val[i-1];
      low_pad[i] = cmp_pad[i-1];
      low_tag[i] = cmp_tag[i-1];
      low_gt[i]  = cmp_gt[i-1];
    end
  end

  // insertion: thermometer edge receives the new sample
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!cmp_gt[i]) begin
        nxt_val[i] = cmp_val[i];
        nxt_pad[i] = cmp_pad[i];
        nxt_tag[i] = cmp_tag[i];
      end else if (!low_gt[i]) begin
        nxt_val[i] = in_sample;
        nxt_pad[i] = 1'b0;
        nxt_tag[i] = wr_ptr;
      end else begin
        nxt_val[i] = low_val[i];
        nxt_pad[i] = low_pad[i];
        nxt_tag[i] = low_tag[i];
      end
    end
  end

endmodule

// File: rtl/rank_fill_ctl.sv
module rank_fill_ctl
  import rank_sel_pkg::*;
#(
  parameter int unsigned DEPTH  = SEL_DEPTH,
  localparam int unsigned TAG_W = $clog2(DEPTH),
  localparam logic [TAG_W-1:0] LAST_PTR = TAG_W'(DEPTH - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [TAG_W-1:0] wr_ptr,
  output logic             full
);

  logic [TAG_W-1:0] ptr_q, ptr_d;
  logic             full_q, full_d;

  always_comb begin
    ptr_d  = ptr_q;
    full_d = full_q;
    if (advance) begin
      if (ptr_q == LAST_PTR) begin
        ptr_d  = '0;
        full_d = 1'b1;
      end else begin
        ptr_d = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      full_q <= 1'b0;
    end else if (advance) begin
      ptr_q  <= ptr_d;
      full_q <= full_d;
    end
  end

  assign wr_ptr = ptr_q;
  assign full   = full_q;

endmodule

// File: rtl/rank_window_sel.sv
module rank_window_sel
  import rank_sel_pkg::*;
#(
  parameter int unsigned DATA_W = SEL_DATA_W,
  parameter int unsigned DEPTH  = SEL_DEPTH,
  parameter int unsigned RANK   = SEL_RANK,
  localparam int unsigned TAG_W    = $clog2(DEPTH),
  localparam int unsigned RANK_IDX = RANK - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_sample,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_rank
);

  logic [DEPTH-1:0][DATA_W-1:0] slot_val_q, nxt_val;
  logic [DEPTH-1:0]             slot_pad_q, nxt_pad;
  logic [DEPTH-1:0][TAG_W-1:0]  slot_tag_q, nxt_tag;
  logic [DEPTH-1:0]             gt_vec;
  logic [DEPTH-1:0]             del_vec;
  logic [TAG_W-1:0]             wr_ptr;
  logic                         full;
  logic [DATA_W-1:0]            rank_q, rank_d;

  rank_slot_cmp #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .TIE    (TIE_NEW_ABOVE)
  ) cmp_i (
    .slot_val  (slot_val_q),
    .slot_pad  (slot_pad_q),
    .slot_tag  (slot_tag_q),
    .in_sample (in_sample),
    .wr_ptr    (wr_ptr),
    .gt_vec    (gt_vec),
    .del_vec   (del_vec)
  );

  rank_shift_net #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) net_i (
    .slot_val  (slot_val_q),
    .slot_pad  (slot_pad_q),
    .slot_tag  (slot_tag_q),
    .gt_vec    (gt_vec),
    .del_vec   (del_vec),
    .in_sample (in_sample),
    .wr_ptr    (wr_ptr),
    .nxt_val   (nxt_val),
    .nxt_pad   (nxt_pad),
    .nxt_tag   (nxt_tag)
  );

  rank_fill_ctl #(
    .DEPTH (DEPTH)
  ) fill_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (in_valid),
    .wr_ptr  (wr_ptr),
    .full    (full)
  );

  // window storage: one register set per slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_store
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_val_q[i] <= '0;
        slot_pad_q[i] <= 1'b1;
        slot_tag_q[i] <= TAG_W'(i);
      end else if (in_valid) begin
        slot_val_q[i] <= nxt_val[i];
        slot_pad_q[i] <= nxt_pad[i];
        slot_tag_q[i] <= nxt_tag[i];
      end
    end
  end

  assign rank_d = nxt_val[RANK_IDX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rank_q <= '0;
    end else if (in_valid) begin
      rank_q <= rank_d;
    end
  end

  assign out_rank  = rank_q;
  assign out_valid = full;

endmodule

// File: rtl/rank_window_sel_chk.sv
module rank_window_sel_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         in_valid,
  input logic [DATA_W-1:0]            in_sample,
  input logic                         out_valid,
  input logic [DATA_W-1:0]            out_rank,
  input logic [DEPTH-1:0][DATA_W-1:0] slot_val,
  input logic [DEPTH-1:0]             slot_pad,
  input logic [DEPTH-1:0]             del_vec
);

  logic [CNT_W-1:0]             acc_cnt;
  logic                         armed;
  logic                         prev_en;
  logic [DATA_W-1:0]            prev_sample;
  logic [DEPTH-1:0][DATA_W-1:0] prev_val;
  logic [DEPTH-1:0]             prev_pad;
  logic                         sorted_ok;
  logic [DEPTH-1:0]             move_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_cnt     <= '0;
      armed       <= 1'b0;
      prev_en     <= 1'b0;
      prev_sample <= '0;
      prev_val    <= '0;
      prev_pad    <= '1;
    end else begin
      armed       <= 1'b1;
      prev_en     <= in_valid;
      prev_sample <= in_sample;
      prev_val    <= slot_val;
      prev_pad    <= slot_pad;
      if (in_valid && acc_cnt != CNT_W'(DEPTH)) acc_cnt <= acc_cnt + 1'b1;
    end
  end

  always_comb begin
    sorted_ok = 1'b1;
    for (int i = 0; i < DEPTH - 1; i++) begin
      if (slot_pad[i] && !slot_pad[i+1]) sorted_ok = 1'b0;
      if (!slot_pad[i] && !slot_pad[i+1] && slot_val[i] > slot_val[i+1]) sorted_ok = 1'b0;
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      move_ok[i] = (!slot_pad[i] && slot_val[i] == prev_sample) ||
                   (slot_pad[i] == prev_pad[i] && slot_val[i] == prev_val[i]);
      if (i > 0)
        if (slot_pad[i] == prev_pad[i-1] && slot_val[i] == prev_val[i-1]) move_ok[i] = 1'b1;
      if (i < DEPTH - 1)
        if (slot_pad[i] == prev_pad[i+1] && slot_val[i] == prev_val[i+1]) move_ok[i] = 1'b1;
    end
  end

  a_r2_valid_count: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (acc_cnt == CNT_W'(DEPTH)));

  a_r2_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);

  a_r4_no_placeholder: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (slot_pad == '0));

  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_rank) && $stable(out_valid) && $stable(slot_val) && $stable(slot_pad)));

  a_r7_sorted: assert property (@(posedge clk) disable iff (!rst_n)
    sorted_ok);

  a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && prev_en) |-> (&move_ok));

  a_r8_one_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(del_vec) == 1);

endmodule

bind rank_window_sel rank_window_sel_chk #(
  .DATA_W (DATA_W),
  .DEPTH  (DEPTH)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_sample (in_sample),
  .out_valid (out_valid),
  .out_rank  (out_rank),
  .slot_val  (slot_val_q),
  .slot_pad  (slot_pad_q),
  .del_vec   (del_vec)
);

// File: tb/rank_window_sel_tb.sv
module rank_window_sel_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 16;
  localparam int WIN        = 32;
  localparam int RK         = 24;
  localparam int WATCHDOG   = 150000;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [DW-1:0] in_sample;
  logic          out_valid;
  logic [DW-1:0] out_rank;

  int n_checks;
  int n_errors;
  bit finished;

  // reference window
  logic [DW-1:0] hist [WIN];
  int            hist_wp;
  int            hist_cnt;

  rank_window_sel #(
    .DATA_W (DW),
    .DEPTH  (WIN),
    .RANK   (RK)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .out_valid (out_valid),
    .out_rank  (out_rank)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [DW-1:0] ref_rank();
    logic [DW-1:0] s [WIN];
    for (int i = 0; i < WIN; i++) s[i] = hist[i];
    for (int i = 1; i < WIN; i++) begin
      logic [DW-1:0] k;
      int j;
      k = s[i];
      j = i - 1;
      while (j >= 0 && s[j] > k) begin
        s[j+1] = s[j];
        j--;
      end
      s[j+1] = k;
    end
    return s[RK-1];
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    hist_wp  = 0;
    hist_cnt = 0;
    for (int i = 0; i < WIN; i++) hist[i] = '0;
  endtask

  // push one sample and compare one clock later
  task automatic push(input logic [DW-1:0] v, input string req);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = v;
    @(posedge clk);
    #1;
    hist[hist_wp] = v;
    hist_wp = (hist_wp + 1) % WIN;
    if (hist_cnt < WIN) hist_cnt++;
    // R2: valid flag tracks the fill count
    check(out_valid == (hist_cnt == WIN), "R2", DW'(out_valid), DW'(hist_cnt == WIN));
    // R3: rank value once the window is full
    if (hist_cnt == WIN) begin
      logic [DW-1:0] e;
      e = ref_rank();
      check(out_rank == e, req, out_rank, e);
    end
  endtask

  // R6: idle cycles keep the outputs
  task automatic idle(input int n);
    logic [DW-1:0] r0;
    logic          v0;
    @(negedge clk);
    in_valid  = 1'b0;
    in_sample = ~in_sample;
    r0 = out_rank;
    v0 = out_valid;
    for (int c = 0; c < n; c++) begin
      @(posedge clk);
      #1;
      check(out_rank == r0 && out_valid == v0, "R6", out_rank, r0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0;
    rst_n    = 1'b0;
    #1;
    // R1: asynchronous clear of outputs
    check(out_valid == 1'b0, "R1", DW'(out_valid), '0);
    check(out_rank == '0, "R1", out_rank, '0);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(posedge clk);
    #1;
    check(out_valid == 1'b0 && out_rank == '0, "R1", out_rank, '0);
  endtask

  initial begin : watchdog
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin : stim
    n_checks  = 0;
    n_errors  = 0;
    finished  = 0;
    in_valid  = 1'b0;
    in_sample = '0;
    rst_n     = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    do_reset();

    // R3 ascending ramp, window fills at the 32nd sample
    for (int i = 0; i < 48; i++) push(DW'(i * 3), "R3");
    idle(4);
    // R3 descending from the top of the range
    for (int i = 0; i < 48; i++) push(DW'(16'hFFFF - i), "R3");
    // R4 alternating extremes
    for (int i = 0; i < 64; i++) push((i % 3 == 0) ? 16'h0000 : 16'hFFFF, "R4");
    // R5 constant run then small-alphabet ties
    for (int i = 0; i < 40; i++) push(16'h1234, "R5");
    for (int i = 0; i < 600; i++) push(DW'($urandom % 4), "R5");

    // R1 reset in mid-run, then R4 fill with only the maximum value
    do_reset();
    for (int i = 0; i < 31; i++) push(16'hFFFF, "R4");
    check(out_valid == 1'b0, "R2", DW'(out_valid), '0);
    push(16'hFFFF, "R4");
    check(out_rank == 16'hFFFF, "R4", out_rank, 16'hFFFF);

    // R3 random with idle gaps
    for (int i = 0; i < 1500; i++) begin
      push(DW'($urandom), "R3");
      if (i % 97 == 0) idle(1 + (i % 5));
    end
    // R5 ties inside a wide random stream
    for (int i = 0; i < 300; i++) push(DW'(16'h8000 + ($urandom % 6)), "R5");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule